// File: doc/BRIEF.md
# Receive Descriptor Frame Writer

This block takes received frames from a byte stream and places them in memory through a ring of receive descriptors. It first holds the opening bytes of each frame, so a frame that is too short can be discarded before any descriptor is read. It then reads the current descriptor and checks that software owns it. If so, it stores the frame at the descriptor's buffer address, writes back a status word that carries the length, and moves to the next descriptor. Every outcome is reported as one-cycle status pulses.

Each accepted frame is also classed by its destination address as unicast, broadcast or multicast, and a set of running counters is updated. All memory traffic uses a simple word interface. A request is held until it is granted, and read data comes back later with a valid strobe. A descriptor is 32 bytes. Its word at byte offset 0 holds the ownership and control bits, the word at offset 4 holds the buffer size field, and the word at offset 8 holds the buffer address.

Top module: `rx_desc_writer`

## Requirements
- R1: At the first byte of a frame, `in_ready` is low while `rx_enable` is low. A refused frame causes no memory access, no status pulse and no counter change.
- R2: A frame that ends before its 12th byte gives one pulse on `st_ri` and `st_nis`. It causes no memory access, and the descriptor pointer and counters do not change.
- R3: If bit 31 of descriptor word 0 is clear, the frame is consumed and discarded. There is one pulse on `st_ru` and `st_ais`, no memory write, no counter change, and the pointer stays on the same descriptor.
- R4: Frame byte i is stored at buffer address (descriptor word 2, assumed word aligned) plus i, packed little-endian into 32-bit words. The last partial word uses byte enables that cover lanes 0 up to the last byte only, so bytes after the frame end are left as they were.
- R5: After the data, the block writes descriptor word 0 with all byte enables set. The value is ((length + 4) << 16) | 0x300, with the length taken to 16 bits. This clears the ownership bit.
- R6: After a write-back, the pointer moves to the receive base if bit 15 of descriptor word 1 is set. Otherwise it advances by 32 bytes. A pulse on `base_load` copies `rx_base` into the pointer.
- R7: A destination address whose first byte has bit 0 clear is unicast. Six bytes of 0xFF is broadcast. Every other destination is multicast.
- R8: On each stored frame, `cnt_bytes` grows by length + 4 and `cnt_frames` grows by one. `cnt_bcast` or `cnt_mcast` grows by one according to R7.
- R9: A stored frame gives one pulse on `st_ri` and `st_nis`, in the same cycle that the counters show the new values.
- R10: `in_ready` is low whenever a memory request is pending. Frames are handled strictly one after another.
- R11: A memory request that is not granted stays asserted in the next cycle, with the same address, direction and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Allows a new frame to start |
| base_load | input | 1 | Loads `rx_base` into the descriptor pointer |
| rx_base | input | 32 | Byte address of the first ring descriptor |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_ready | output | 1 | Block takes the byte this cycle |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_gnt | input | 1 | Request taken this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| st_ri | output | 1 | Receive-done status pulse |
| st_nis | output | 1 | Normal summary status pulse |
| st_ru | output | 1 | Descriptor unavailable pulse |
| st_ais | output | 1 | Abnormal summary status pulse |
| cnt_bytes | output | CNT_W | Stored bytes, including 4 per frame |
| cnt_frames | output | CNT_W | Stored frames |
| cnt_bcast | output | CNT_W | Stored broadcast frames |
| cnt_mcast | output | CNT_W | Stored multicast frames |

## Verification
The assertions assume a well-behaved environment. Read data must come back only for a granted read, with one read in flight at a time. Descriptor buffer addresses must be word aligned. No frame may reach 64 KiB. The bench stays within these limits: its memory model answers each granted read exactly one cycle later and withholds the grant in a fixed repeating pattern. It places every buffer on a word boundary and sends frames of at most 40 bytes. It also lowers `in_valid` after each frame, so a refused frame never starts once receive is enabled again.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;

  typedef enum logic [3:0] {
    ST_HEAD,   // collecting the opening bytes
    ST_RREQ,   // issuing a descriptor word read
    ST_RRSP,   // waiting for descriptor read data
    ST_HWR,    // writing the held opening words
    ST_BODY,   // packing further bytes
    ST_BWR,    // writing a packed word
    ST_DROP,   // consuming an unowned frame
    ST_WB      // descriptor write-back
  } rx_state_t;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_BCAST = 2'd1,
    CLS_MCAST = 2'd2
  } dst_class_t;

  localparam logic [31:0] WB_FIXED = 32'h0000_0300;

  // status word: reported length (frame plus four check bytes) in the top half
  function automatic logic [31:0] wb_status(input logic [15:0] nbytes);
    logic [15:0] rep;
    rep = nbytes + 16'd4;
    return {rep, 16'h0000} | WB_FIXED;
  endfunction

  // byte enables for lanes 0..top
  function automatic logic [3:0] lanes_upto(input logic [1:0] top);
    case (top)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      2'd2:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] ring_next(input logic [31:0] cur,
                                            input logic [31:0] base,
                                            input logic        wrap,
                                            input logic [31:0] step);
    return wrap ? base : cur + step;
  endfunction

endpackage

// File: rtl/rxdw_classify.sv
module rxdw_classify
  import rxdw_pkg::*;
(
  input  logic [47:0] dst,   // byte 0 in bits 7:0
  output dst_class_t  cls
);

  always_comb begin
    if (!dst[0])      cls = CLS_UNI;
    else if (&dst)    cls = CLS_BCAST;
    else              cls = CLS_MCAST;
  end

endmodule

// File: rtl/rxdw_stats.sv
module rxdw_stats
  import rxdw_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [15:0]      nbytes,
  input  dst_class_t       cls,
  output logic [CNT_W-1:0] bytes_o,
  output logic [CNT_W-1:0] frames_o,
  output logic [CNT_W-1:0] bcast_o,
  output logic [CNT_W-1:0] mcast_o
);

  localparam logic [CNT_W-1:0] CRC_ADD = CNT_W'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_o  <= '0;
      frames_o <= '0;
      bcast_o  <= '0;
      mcast_o  <= '0;
    end else if (upd) begin
      bytes_o  <= bytes_o + CNT_W'(nbytes) + CRC_ADD;
      frames_o <= frames_o + CNT_W'(1);
      if (cls == CLS_BCAST) bcast_o <= bcast_o + CNT_W'(1);
      if (cls == CLS_MCAST) mcast_o <= mcast_o + CNT_W'(1);
    end
  end

  assert_frames_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> frames_o == $past(frames_o) + CNT_W'(1));

  assert_class_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bcast_o != $past(bcast_o) && mcast_o != $past(mcast_o)));

endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rxdw_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int DESC_STEP = 32,
  parameter int MIN_LEN   = 12,   // multiple of 4, at least 8
  parameter int WRAP_BIT  = 15,
  parameter int OWN_BIT   = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic             base_load,
  input  logic [31:0]      rx_base,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  output logic             st_ri,
  output logic             st_nis,
  output logic             st_ru,
  output logic             st_ais,
  output logic [CNT_W-1:0] cnt_bytes,
  output logic [CNT_W-1:0] cnt_frames,
  output logic [CNT_W-1:0] cnt_bcast,
  output logic [CNT_W-1:0] cnt_mcast
);

  localparam int          HEAD_WORDS = MIN_LEN / 4;
  localparam int          HI_W       = $clog2(MIN_LEN);
  localparam int          HS_W       = $clog2(HEAD_WORDS);
  localparam logic [1:0]  LAST_DIDX  = 2'd2;   // three descriptor words read
  localparam logic [15:0] MIN_M1     = 16'(MIN_LEN - 1);
  localparam logic [13:0] HEAD_LASTW = 14'(HEAD_WORDS - 1);
  localparam logic [31:0] STEP       = 32'(DESC_STEP);

  rx_state_t              state_q;
  logic [15:0]            len_q;
  logic [MIN_LEN*8-1:0]   head_q;
  logic                   last_seen_q;
  logic [1:0]             didx_q;
  logic                   own_q;
  logic                   wrap_q;
  logic [31:0]            dbuf_q;
  logic [13:0]            wcnt_q;
  logic [31:0]            pk_q;
  logic [1:0]             pkn_q;
  logic [3:0]             pkbe_q;
  logic                   pklast_q;
  logic [31:0]            cur_ptr_q;

  // named internal events
  logic       accept, head_first, runt_ev, head_full, fetch_done, drop_ev, wb_fire;
  dst_class_t dst_cls;
  logic [HS_W-1:0] hsel;

  assign accept     = in_valid && in_ready;
  assign head_first = accept && (state_q == ST_HEAD) && (len_q == 16'd0);
  assign runt_ev    = accept && (state_q == ST_HEAD) && in_last && (len_q < MIN_M1);
  assign head_full  = accept && (state_q == ST_HEAD) && (len_q == MIN_M1);
  assign fetch_done = (state_q == ST_RRSP) && mem_rvalid && (didx_q == LAST_DIDX);
  assign drop_ev    = fetch_done && !own_q;
  assign wb_fire    = (state_q == ST_WB) && mem_gnt;
  assign hsel       = wcnt_q[HS_W-1:0];

  rxdw_classify u_cls (
    .dst (head_q[47:0]),
    .cls (dst_cls)
  );

  rxdw_stats #(.CNT_W(CNT_W)) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (wb_fire),
    .nbytes   (len_q),
    .cls      (dst_cls),
    .bytes_o  (cnt_bytes),
    .frames_o (cnt_frames),
    .bcast_o  (cnt_bcast),
    .mcast_o  (cnt_mcast)
  );

  always_comb begin
    case (state_q)
      ST_HEAD:          in_ready = (len_q != 16'd0) || rx_enable;
      ST_BODY, ST_DROP: in_ready = 1'b1;
      default:          in_ready = 1'b0;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr_q;
    mem_wdata = '0;
    mem_be    = 4'hF;
    case (state_q)
      ST_RREQ: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr_q + {28'd0, didx_q, 2'b00};
      end
      ST_HWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dbuf_q + {16'd0, wcnt_q, 2'b00};
        mem_wdata = head_q[{hsel, 5'b00000} +: 32];
      end
      ST_BWR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dbuf_q + {16'd0, wcnt_q, 2'b00};
        mem_wdata = pk_q;
        mem_be    = pkbe_q;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = wb_status(len_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_HEAD;
      len_q       <= '0;
      head_q      <= '0;
      last_seen_q <= 1'b0;
      didx_q      <= '0;
      own_q       <= 1'b0;
      wrap_q      <= 1'b0;
      dbuf_q      <= '0;
      wcnt_q      <= '0;
      pk_q        <= '0;
      pkn_q       <= '0;
      pkbe_q      <= '0;
      pklast_q    <= 1'b0;
      cur_ptr_q   <= '0;
      st_ri       <= 1'b0;
      st_nis      <= 1'b0;
      st_ru       <= 1'b0;
      st_ais      <= 1'b0;
    end else begin
      st_ri  <= runt_ev || wb_fire;
      st_nis <= runt_ev || wb_fire;
      st_ru  <= drop_ev;
      st_ais <= drop_ev;

      case (state_q)
        ST_HEAD: if (accept) begin
          head_q[{len_q[HI_W-1:0], 3'b000} +: 8] <= in_data;
          if (runt_ev) begin
            len_q <= '0;
          end else begin
            len_q <= len_q + 16'd1;
            if (head_full) begin
              last_seen_q <= in_last;
              didx_q      <= '0;
              state_q     <= ST_RREQ;
            end
          end
        end
        ST_RREQ: if (mem_gnt) state_q <= ST_RRSP;
        ST_RRSP: if (mem_rvalid) begin
          case (didx_q)
            2'd0:    own_q  <= mem_rdata[OWN_BIT];
            2'd1:    wrap_q <= mem_rdata[WRAP_BIT];
            default: dbuf_q <= mem_rdata;
          endcase
          didx_q <= didx_q + 2'd1;
          if (!fetch_done) begin
            state_q <= ST_RREQ;
          end else if (own_q) begin
            wcnt_q  <= '0;
            state_q <= ST_HWR;
          end else begin
            len_q   <= '0;
            state_q <= last_seen_q ? ST_HEAD : ST_DROP;
          end
        end
        ST_HWR: if (mem_gnt) begin
          wcnt_q <= wcnt_q + 14'd1;
          if (wcnt_q == HEAD_LASTW) begin
            pk_q    <= '0;
            pkn_q   <= '0;
            state_q <= last_seen_q ? ST_WB : ST_BODY;
          end
        end
        ST_BODY: if (accept) begin
          pk_q[{pkn_q, 3'b000} +: 8] <= in_data;
          len_q <= len_q + 16'd1;
          if (pkn_q == 2'd3 || in_last) begin
            pkbe_q   <= lanes_upto(pkn_q);
            pklast_q <= in_last;
            state_q  <= ST_BWR;
          end else begin
            pkn_q <= pkn_q + 2'd1;
          end
        end
        ST_BWR: if (mem_gnt) begin
          wcnt_q  <= wcnt_q + 14'd1;
          pk_q    <= '0;
          pkn_q   <= '0;
          state_q <= pklast_q ? ST_WB : ST_BODY;
        end
        ST_DROP: if (accept && in_last) state_q <= ST_HEAD;
        ST_WB: if (mem_gnt) begin
          len_q   <= '0;
          state_q <= ST_HEAD;
        end
        default: state_q <= ST_HEAD;
      endcase

      if (base_load)    cur_ptr_q <= rx_base;
      else if (wb_fire) cur_ptr_q <= ring_next(cur_ptr_q, rx_base, wrap_q, STEP);
    end
  end

  // ---------------- assertions ----------------
  assert_start_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    head_first |-> rx_enable);

  assert_runt_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    runt_ev |-> !mem_req);

  assert_wb_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> own_q);

  assert_be_contig_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be == 4'b0001 || mem_be == 4'b0011 ||
                             mem_be == 4'b0111 || mem_be == 4'b1111));

  assert_ring_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && !base_load && !wrap_q) |=> cur_ptr_q == $past(cur_ptr_q) + STEP);

  assert_pulse_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ri == st_nis) && (st_ru == st_ais) && !(st_ri && st_ru));

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !in_ready);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

endmodule

// File: tb/rx_desc_writer_test.sv
`timescale 1ns/1ps
module rx_desc_writer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_enable = 1'b0, base_load = 1'b0;
  logic [31:0] rx_base = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic st_ri, st_nis, st_ru, st_ais;
  logic [31:0] cnt_bytes, cnt_frames, cnt_bcast, cnt_mcast;

  always #2 clk = ~clk;   // 250 MHz

  rx_desc_writer uut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .base_load(base_load),
    .rx_base(rx_base), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .st_ri(st_ri), .st_nis(st_nis), .st_ru(st_ru), .st_ais(st_ais),
    .cnt_bytes(cnt_bytes), .cnt_frames(cnt_frames), .cnt_bcast(cnt_bcast),
    .cnt_mcast(cnt_mcast)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [0:1023];
  logic [3:0]  gcyc = '0;
  logic        rv_r = 1'b0;
  logic [31:0] rd_r = '0;
  assign mem_gnt    = (gcyc[1:0] != 2'd3);
  assign mem_rvalid = rv_r;
  assign mem_rdata  = rd_r;

  always @(posedge clk) begin
    gcyc <= gcyc + 4'd1;
    rv_r <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
      end else begin
        rv_r <= 1'b1;
        rd_r <= mem[mem_addr[11:2]];
      end
    end
  end

  // ---------------- port monitors ----------------
  int n_ri = 0, n_nis = 0, n_ru = 0, n_ais = 0, n_wr = 0, n_acc = 0, v10 = 0, v11 = 0;
  logic        p_wait = 1'b0, p_we = 1'b0;
  logic [31:0] p_addr = '0, p_wd = '0;
  always @(negedge clk) begin
    if (st_ri)  n_ri++;
    if (st_nis) n_nis++;
    if (st_ru)  n_ru++;
    if (st_ais) n_ais++;
    if (mem_req && mem_gnt) n_acc++;
    if (mem_req && mem_gnt && mem_we) n_wr++;
    if (in_ready && mem_req) v10++;
    if (p_wait && !(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wd)) v11++;
    p_wait = mem_req && !mem_gnt;
    p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
  end

  // ---------------- bookkeeping ----------------
  int tests = 0, fails = 0;
  bit finished = 0;
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic [7:0] fb [0:255];
  logic [31:0] e_bytes = 0, e_frames = 0, e_bcast = 0, e_mcast = 0;
  logic [31:0] base_now = 0, ring_last = 32'h60, exp_ptr = 0;

  function automatic logic [31:0] buf_of(input logic [31:0] d);
    return 32'h400 + (d >> 5) * 32'h100;
  endfunction

  task automatic arm_desc(input logic [31:0] d);
    mem[d[11:2]]     = 32'h8000_0000;
    mem[d[11:2] + 1] = (d == ring_last) ? 32'h0000_8100 : 32'h0000_0100;
    mem[d[11:2] + 2] = buf_of(d);
  endtask

  task automatic build(input int len, input int cls, input int seed);
    for (int i = 0; i < 256; i++) fb[i] = 8'(i * 7 + seed * 13 + 5);
    case (cls)
      0: fb[0] = {fb[0][7:1], 1'b0};
      1: for (int i = 0; i < 6; i++) fb[i] = 8'hFF;
      2: begin fb[0] = fb[0] | 8'h01; fb[1] = 8'h00; end
      default: begin for (int i = 0; i < 5; i++) fb[i] = 8'hFF; fb[5] = 8'hFE; end
    endcase
  endtask

  task automatic send_frame(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[i]; in_last = (i == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_evt(input int prev, input string req);
    int t = 0;
    while ((n_ri + n_ru) == prev && t < 2000) begin @(negedge clk); #2; t++; end
    check(t < 2000, req, t, 0);
    repeat (3) @(negedge clk);
    #2;
  endtask

  task automatic check_counters(input string req);
    check(cnt_bytes == e_bytes, {req, " R8 bytes"}, cnt_bytes, e_bytes);
    check(cnt_frames == e_frames, {req, " R8 frames"}, cnt_frames, e_frames);
    check(cnt_bcast == e_bcast, {req, " R7 bcast"}, cnt_bcast, e_bcast);
    check(cnt_mcast == e_mcast, {req, " R7 mcast"}, cnt_mcast, e_mcast);
  endtask

  task automatic run_good(input int len, input int cls, input int seed);
    logic [31:0] d, b, w, exp_w;
    int bad, a;
    d = exp_ptr; b = buf_of(d);
    for (int i = 0; i < 64; i++) mem[b[11:2] + i] = 32'hA5A5_A5A5;
    arm_desc(d);
    build(len, cls, seed);
    a = n_ri + n_ru;
    send_frame(len);
    wait_evt(a, "R9 completion");
    e_bytes += len + 4; e_frames++;
    if (cls == 1) e_bcast++;
    if (cls >= 2) e_mcast++;
    w = mem[d[11:2]];
    exp_w = ((len + 4) << 16) | 32'h300;
    check(w == exp_w, "R5/R6 write-back at expected descriptor", w, exp_w);
    bad = 0;
    for (int i = 0; i < len; i++)
      if (mem[(b + i) >> 2][8*((b + i) % 4) +: 8] != fb[i]) bad++;
    check(bad == 0, "R4 buffer bytes", bad, 0);
    bad = 0;
    for (int i = len; i % 4 != 0; i++)
      if (mem[(b + i) >> 2][8*((b + i) % 4) +: 8] != 8'hA5) bad++;
    check(bad == 0, "R4 bytes past end untouched", bad, 0);
    check_counters("R9");
    check(n_ri == n_nis && n_ru == n_ais, "R9 pulse pairing", n_nis, n_ri);
    exp_ptr = (d == ring_last) ? base_now : d + 32;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int a, w0, acc0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(in_ready == 1'b0, "R1 reset ready low", in_ready, 0);
    check(mem_req == 1'b0, "R10 reset no request", mem_req, 0);
    check({st_ri, st_ru} == 2'b00, "R9 reset no pulse", {st_ri, st_ru}, 0);
    check_counters("reset");

    @(negedge clk); base_load = 1'b1; rx_base = 32'h0;
    @(negedge clk); base_load = 1'b0;

    // R1: disabled, frame offered for a while
    build(20, 0, 1);
    a = n_ri + n_ru; acc0 = n_acc;
    in_valid = 1'b1; in_data = fb[0];
    for (int i = 0; i < 20; i++) begin
      #1; if (in_ready) w0 = 1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(w0 != 1, "R1 ready held low while disabled", w0, 0);
    check((n_ri + n_ru) == a && n_acc == acc0, "R1 no status or memory", n_acc - acc0, 0);
    check_counters("R1");

    rx_enable = 1'b1;
    // R2: runts of every short length
    for (int len = 1; len < 12; len++) begin
      build(len, len % 3, len);
      a = n_ri; acc0 = n_acc;
      send_frame(len);
      wait_evt(a, "R2 runt pulse");
      check(n_ri == a + 1 && n_nis == n_ri, "R2 runt RI/NIS once", n_ri - a, 1);
      check(n_acc == acc0, "R2 runt no memory access", n_acc - acc0, 0);
      check_counters("R2");
    end

    // sweep lengths and classes over the 4-entry ring (wraps several times)
    for (int len = 12; len <= 40; len++) run_good(len, len % 4, len);

    // R3: descriptor not owned, short and long frames
    for (int k = 0; k < 2; k++) begin
      mem[exp_ptr[11:2]] = 32'h0000_1234;
      build(k ? 30 : 12, 2, 40 + k);
      a = n_ru; acc0 = n_wr;
      send_frame(k ? 30 : 12);
      wait_evt(n_ri + a, "R3 drop event");
      check(n_ru == a + 1 && n_ais == n_ru, "R3 RU/AIS once", n_ru - a, 1);
      check(n_wr == acc0, "R3 no writes", n_wr - acc0, 0);
      check(mem[exp_ptr[11:2]] == 32'h0000_1234, "R3 descriptor untouched",
            mem[exp_ptr[11:2]], 32'h1234);
      check_counters("R3");
    end
    run_good(20, 1, 77);   // lands on the same descriptor: pointer did not move (R3)

    // R6: new base, two-entry ring
    @(negedge clk); rx_base = 32'h80; base_load = 1'b1;
    @(negedge clk); base_load = 1'b0;
    base_now = 32'h80; ring_last = 32'hA0; exp_ptr = 32'h80;
    for (int k = 0; k < 3; k++) run_good(13 + k, k, 90 + k);

    check(v10 == 0, "R10 ready low during memory traffic", v10, 0);
    check(v11 == 0, "R11 request held until grant", v11, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule